// File: doc/BRIEF.md
# Nibble Video Stream Rebuilder

This block sits behind a camera data bus and turns it back into whole 8-bit luma and chroma samples. The bus is either a full byte lane or a 4-bit lane carried on the upper four pins of the byte bus. In the 4-bit case each byte takes two pixel beats, most significant half first. Every beat is qualified by a pixel clock enable and a line-valid flag. The rebuilt bytes come out as one stream. Each output byte carries a 2-bit tag marking it as luma, blue-difference or red-difference chroma, and a flag on the first byte of each line.

Within a line the samples are interleaved with chroma first: chroma, luma, the other chroma, luma, and then the pattern repeats. A configuration input selects which chroma component leads. A second one mirrors the bit order of every byte. Whenever line-valid is seen low on a beat, both the half-byte state and the chroma/luma phase go back to their starting point. A byte that was left half built is then thrown away.

Top module: `nibble_stream_rebuild`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `out_valid` is low. The first byte after reset is treated as the first byte of a line.
- R2: In byte mode (`cfg_nibble`=0), each beat with `pix_en`=1 and `line_vld`=1 produces one output byte equal to `din`. `out_valid` goes high in the cycle after that beat.
- R3: In nibble mode (`cfg_nibble`=1), only `din[7:4]` is used. The first accepted beat gives bits 7:4 of the byte and the second gives bits 3:0. The byte appears in the cycle after the second beat, and `din[3:0]` has no effect.
- R4: Within a line, output bytes follow a repeating four-step pattern: leading chroma, luma, trailing chroma, luma. The tag codes are luma=2'b00, blue chroma=2'b01 and red chroma=2'b10. The code 2'b11 is never produced.
- R5: With `cfg_u_first`=1 the leading chroma is blue (01) and the trailing chroma is red (10). With `cfg_u_first`=0 the two are exchanged. This holds in both modes.
- R6: With `cfg_bitrev`=1, bit i of `out_data` equals bit 7-i of the assembled byte.
- R7: A beat with `line_vld`=0 produces no output. Cycles with `pix_en`=0 produce no output and leave the phase unchanged, whatever `din` and `line_vld` carry.
- R8: A beat with `pix_en`=1 and `line_vld`=0 returns the pattern of R4 to its leading-chroma step and the nibble position to the high half.
- R9: If that line-end beat arrives after only the high half of a byte, the half byte is discarded and never appears at the output.
- R10: `out_sol` is 1 on the first output byte after reset or after a line-end beat, and 0 on every other output byte. That first byte always carries a chroma tag.
- R11: `out_valid` is high for exactly one cycle per rebuilt byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel beat enable; the bus is sampled only when high |
| line_vld | input | 1 | Line-valid qualifier, sampled on beats |
| din | input | 8 | Camera data bus; the upper four bits are used in nibble mode |
| cfg_nibble | input | 1 | 1 selects the 4-bit bus mode, 0 selects byte mode |
| cfg_u_first | input | 1 | 1 puts blue chroma first in each pair, 0 puts red chroma first |
| cfg_bitrev | input | 1 | 1 mirrors the bit order of each rebuilt byte |
| out_valid | output | 1 | One-cycle strobe for each rebuilt byte |
| out_tag | output | 2 | Component tag: 00 luma, 01 blue chroma, 10 red chroma |
| out_data | output | 8 | Rebuilt sample byte |
| out_sol | output | 1 | High on the first byte of a line |

## Verification
Line restart and byte completion compete for the same beat. This happens when `line_vld` drops on the beat that would have supplied the low half of a byte. It also happens when a new line starts right after a dropped half. The bench provokes both in nibble mode by ending a line after a single nibble and then starting the next line with a different high nibble. It then judges two things: that no byte was produced from the stale half, and that the first rebuilt byte combines the two new nibbles, carries the leading-chroma tag and has `out_sol` set. Gaps in `pix_en` in the middle of a line are also checked, to show that phase is held rather than advanced.

// File: rtl/vnib_pkg.sv
package vnib_pkg;

    // Component tag carried with every rebuilt byte
    typedef enum logic [1:0] {
        TAG_Y  = 2'b00,
        TAG_CB = 2'b01,
        TAG_CR = 2'b10
    } lane_tag_e;

    // Position inside the four-byte chroma/luma pattern
    localparam int PHASE_W = 2;

endpackage

// File: rtl/nib_assembler.sv
module nib_assembler #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_en,
    input  logic              line_vld,
    input  logic              cfg_nibble,
    input  logic [DATA_W-1:0] din,
    output logic              byte_stb,
    output logic [DATA_W-1:0] byte_val,
    output logic              byte_first
);
    localparam int HALF_W = DATA_W / 2;

    typedef struct packed {
        logic              half_full;
        logic [HALF_W-1:0] hold;
        logic              sol_pend;
    } asm_state_t;

    asm_state_t st_d, st_q;
    logic [HALF_W-1:0] nib_in;

    assign nib_in = din[DATA_W-1 -: HALF_W];

    always_comb begin
        st_d       = st_q;
        byte_stb   = 1'b0;
        byte_val   = din;
        byte_first = st_q.sol_pend;
        if (pix_en) begin
            if (!line_vld) begin
                // line gap: drop any half byte, restart at the high half
                st_d.half_full = 1'b0;
                st_d.sol_pend  = 1'b1;
            end else if (cfg_nibble) begin
                if (!st_q.half_full) begin
                    st_d.half_full = 1'b1;
                    st_d.hold      = nib_in;
                end else begin
                    st_d.half_full = 1'b0;
                    st_d.sol_pend  = 1'b0;
                    byte_stb       = 1'b1;
                    byte_val       = {st_q.hold, nib_in};
                end
            end else begin
                st_d.half_full = 1'b0;
                st_d.sol_pend  = 1'b0;
                byte_stb       = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.half_full <= 1'b0;
            st_q.hold      <= '0;
            st_q.sol_pend  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: bytes come only from qualified beats
    assert_accept_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |-> (pix_en && line_vld));

    // R9: after a line gap in nibble mode, the very next beat cannot finish a byte
    assert_drop_half_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && !line_vld && cfg_nibble) |=> !(byte_stb && cfg_nibble));

endmodule

// File: rtl/lane_tagger.sv
module lane_tagger
    import vnib_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_stb,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_first,
    input  logic              cfg_u_first,
    input  logic              cfg_bitrev,
    output logic              out_valid,
    output logic [1:0]        out_tag,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sol
);
    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        logic               valid;
        lane_tag_e          tag;
        logic [DATA_W-1:0]  data;
        logic               sol;
    } tag_state_t;

    tag_state_t st_d, st_q;
    logic [DATA_W-1:0]  rev_data;
    logic [PHASE_W-1:0] cur_ph;
    lane_tag_e          cur_tag;

    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_rev
        assign rev_data[gi] = in_data[DATA_W-1-gi];
    end

    always_comb begin
        st_d       = st_q;
        cur_ph     = in_first ? '0 : st_q.phase;
        unique case (cur_ph)
            2'd0:    cur_tag = cfg_u_first ? TAG_CB : TAG_CR;
            2'd2:    cur_tag = cfg_u_first ? TAG_CR : TAG_CB;
            default: cur_tag = TAG_Y;
        endcase
        st_d.valid = in_stb;
        if (in_stb) begin
            st_d.phase = cur_ph + 1'b1;
            st_d.tag   = cur_tag;
            st_d.data  = cfg_bitrev ? rev_data : in_data;
            st_d.sol   = in_first;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= '0;
            st_q.valid <= 1'b0;
            st_q.tag   <= TAG_Y;
            st_q.data  <= '0;
            st_q.sol   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_tag   = st_q.tag;
    assign out_data  = st_q.data;
    assign out_sol   = st_q.sol;

    // R4: reserved tag code never leaves the block
    assert_tag_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_tag != 2'b11));

    // R10: a line always opens on a chroma sample
    assert_sol_chroma_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sol) |-> (out_tag != TAG_Y));

    // R11: every output strobe answers exactly one assembled byte
    assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_stb));

endmodule

// File: rtl/nibble_stream_rebuild.sv
module nibble_stream_rebuild #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_en,
    input  logic              line_vld,
    input  logic [DATA_W-1:0] din,
    input  logic              cfg_nibble,
    input  logic              cfg_u_first,
    input  logic              cfg_bitrev,
    output logic              out_valid,
    output logic [1:0]        out_tag,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sol
);
    logic              asm_stb;
    logic [DATA_W-1:0] asm_val;
    logic              asm_first;

    nib_assembler #(.DATA_W(DATA_W)) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_en     (pix_en),
        .line_vld   (line_vld),
        .cfg_nibble (cfg_nibble),
        .din        (din),
        .byte_stb   (asm_stb),
        .byte_val   (asm_val),
        .byte_first (asm_first)
    );

    lane_tagger #(.DATA_W(DATA_W)) u_tag (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_stb      (asm_stb),
        .in_data     (asm_val),
        .in_first    (asm_first),
        .cfg_u_first (cfg_u_first),
        .cfg_bitrev  (cfg_bitrev),
        .out_valid   (out_valid),
        .out_tag     (out_tag),
        .out_data    (out_data),
        .out_sol     (out_sol)
    );

    // R2: an output needs a qualified beat one cycle earlier
    assert_lat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(pix_en && line_vld));

endmodule

// File: tb/nibble_stream_rebuild_tb.sv
module nibble_stream_rebuild_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pix_en = 1'b0;
    logic       line_vld = 1'b0;
    logic [7:0] din = 8'h00;
    logic       cfg_nibble = 1'b0;
    logic       cfg_u_first = 1'b1;
    logic       cfg_bitrev = 1'b0;
    logic       out_valid;
    logic [1:0] out_tag;
    logic [7:0] out_data;
    logic       out_sol;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    nibble_stream_rebuild dut_i (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .line_vld(line_vld),
        .din(din), .cfg_nibble(cfg_nibble), .cfg_u_first(cfg_u_first),
        .cfg_bitrev(cfg_bitrev), .out_valid(out_valid), .out_tag(out_tag),
        .out_data(out_data), .out_sol(out_sol)
    );

    // Vector layout: [23] nibble [22] u_first [21] bitrev [20] line_vld
    // [19:12] din [11] exp valid [10:9] exp tag [8:1] exp data [0] exp sol
    localparam int NV = 29;
    localparam logic [23:0] VECS [0:NV-1] = '{
        // byte mode, blue first (R2 R4 R5 R10)
        {4'b0010, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0},
        {4'b0101, 8'h10, 1'b1, 2'd1, 8'h10, 1'b1},
        {4'b0101, 8'h20, 1'b1, 2'd0, 8'h20, 1'b0},
        {4'b0101, 8'h30, 1'b1, 2'd2, 8'h30, 1'b0},
        {4'b0101, 8'h40, 1'b1, 2'd0, 8'h40, 1'b0},
        {4'b0101, 8'h50, 1'b1, 2'd1, 8'h50, 1'b0},
        {4'b0100, 8'h55, 1'b0, 2'd0, 8'h00, 1'b0},
        // byte mode, red first (R5 R8)
        {4'b0001, 8'h11, 1'b1, 2'd2, 8'h11, 1'b1},
        {4'b0001, 8'h22, 1'b1, 2'd0, 8'h22, 1'b0},
        {4'b0001, 8'h33, 1'b1, 2'd1, 8'h33, 1'b0},
        {4'b0000, 8'h44, 1'b0, 2'd0, 8'h00, 1'b0},
        // byte mode, mirrored bits (R6)
        {4'b0111, 8'h01, 1'b1, 2'd1, 8'h80, 1'b1},
        {4'b0111, 8'hC4, 1'b1, 2'd0, 8'h23, 1'b0},
        {4'b0110, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0},
        // nibble mode, blue first (R3 R4)
        {4'b1101, 8'hA5, 1'b0, 2'd0, 8'h00, 1'b0},
        {4'b1101, 8'h3F, 1'b1, 2'd1, 8'hA3, 1'b1},
        {4'b1101, 8'h70, 1'b0, 2'd0, 8'h00, 1'b0},
        {4'b1101, 8'hE9, 1'b1, 2'd0, 8'h7E, 1'b0},
        {4'b1101, 8'h10, 1'b0, 2'd0, 8'h00, 1'b0},
        {4'b1101, 8'h20, 1'b1, 2'd2, 8'h12, 1'b0},
        {4'b1100, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0},
        // nibble mode, half byte dropped at line end (R9 R8)
        {4'b1101, 8'h90, 1'b0, 2'd0, 8'h00, 1'b0},
        {4'b1100, 8'h50, 1'b0, 2'd0, 8'h00, 1'b0},
        {4'b1101, 8'hC0, 1'b0, 2'd0, 8'h00, 1'b0},
        {4'b1101, 8'hD0, 1'b1, 2'd1, 8'hCD, 1'b1},
        {4'b1100, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0},
        // nibble mode, red first, mirrored (R5 R6)
        {4'b1011, 8'h10, 1'b0, 2'd0, 8'h00, 1'b0},
        {4'b1011, 8'h20, 1'b1, 2'd2, 8'h48, 1'b1},
        {4'b1010, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0}
    };

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic beat(input logic pe, input logic lv, input logic [7:0] d);
        pix_en   = pe;
        line_vld = lv;
        din      = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_out(input logic ev, input logic [1:0] et, input logic [7:0] ed,
                              input logic es, input string req);
        check(out_valid == ev, req, {7'd0, out_valid}, {7'd0, ev});
        if (ev) begin
            check(out_tag == et, req, {6'd0, out_tag}, {6'd0, et});
            check(out_data == ed, req, out_data, ed);
            check(out_sol == es, req, {7'd0, out_sol}, {7'd0, es});
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 in reset", {7'd0, out_valid}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 after release", {7'd0, out_valid}, 8'h00);

        // table walk
        for (int i = 0; i < NV; i++) begin
            cfg_nibble  = VECS[i][23];
            cfg_u_first = VECS[i][22];
            cfg_bitrev  = VECS[i][21];
            beat(1'b1, VECS[i][20], VECS[i][19:12]);
            expect_out(VECS[i][11], VECS[i][10:9], VECS[i][8:1], VECS[i][0],
                       $sformatf("R2-table vec %0d", i));
        end

        // R7 R11: pix_en gaps in the middle of a line hold phase
        cfg_nibble = 1'b0; cfg_u_first = 1'b1; cfg_bitrev = 1'b0;
        beat(1'b0, 1'b1, 8'hAA);
        expect_out(1'b0, 2'd0, 8'h00, 1'b0, "R7 no beat");
        beat(1'b1, 1'b1, 8'hAA);
        expect_out(1'b1, 2'd1, 8'hAA, 1'b1, "R10 first byte");
        beat(1'b0, 1'b1, 8'hFF);
        expect_out(1'b0, 2'd0, 8'h00, 1'b0, "R11 single pulse");
        beat(1'b0, 1'b0, 8'hEE);
        expect_out(1'b0, 2'd0, 8'h00, 1'b0, "R7 gated line low");
        beat(1'b1, 1'b1, 8'hBB);
        expect_out(1'b1, 2'd0, 8'hBB, 1'b0, "R7 phase held");

        // R1 R10: reset in mid-line restarts the pattern
        rst_n = 1'b0;
        beat(1'b1, 1'b1, 8'hCC);
        check(out_valid == 1'b0, "R1 mid reset", {7'd0, out_valid}, 8'h00);
        rst_n = 1'b1;
        beat(1'b1, 1'b1, 8'h61);
        expect_out(1'b1, 2'd1, 8'h61, 1'b1, "R10 after reset");
        beat(1'b1, 1'b1, 8'h62);
        expect_out(1'b1, 2'd0, 8'h62, 1'b0, "R4 after reset");

        pix_en = 1'b0;
        @(negedge clk);
        finish_run();
    end

endmodule